// File: doc/BRIEF.md
# Table Read Pointer Unit

This block lets a small 8-bit controller read constant data out of its 16-bit-wide program memory. Three 8-bit pointer registers (upper, middle, lower) hold a word address. A read command looks up the addressed word and splits it into two byte results: the lower byte goes to an accumulator-side output and the upper byte to a separate result register. Both results are ready one clock after the command, marked by a done pulse.

Software moves the pointer through a table in three ways. It can write any pointer byte. It can step the lower or the middle byte by one, which raises a one-cycle skip indication when the stepped byte lands on zero. It can add an 8-bit value to the lower byte, which records a carry flag.

The lower byte never carries into the middle byte on its own. Software uses the skip indication or the carry flag to decide when to step the middle byte. The program space is 12 bits wide by default, so only the lower four bits of the middle byte take part in the address. A nonzero upper byte makes the read out of range. The program memory is modelled inside the block as a synchronous lookup whose contents are computed from the address.

Top module: `tblptr_unit`

## Requirements
- R1: After reset, all three pointer bytes, both result registers, the carry flag, the skip output, the done output and the out-of-range output are zero.
- R2: A write command for a pointer byte loads `wr_data` into that byte at the next clock edge.
- R3: A read command forms the word address as {middle[ADDR_W-9:0], lower}. One clock later `acc_out` holds the word's lower byte, `res_hi` holds its upper byte and `rd_done` is high for that single cycle. The word stored at address a is: upper byte = a[15:8] XOR (a[3:0] shifted left by 4) XOR 96h; lower byte = a[7:0] XOR C3h.
- R4: Stepping the lower byte from FFh gives 00h, and the middle byte keeps its value.
- R5: Adding `add_val` to the lower byte stores the sum modulo 256 and sets the carry flag to the carry out of bit 7. The middle byte is not changed.
- R6: `skip` is high for the one cycle after a step command that was applied and left the stepped byte at zero. It is low after any other cycle.
- R7: A read issued while the upper pointer byte is nonzero raises `rd_oob` together with `rd_done`, and both result registers load zero. `rd_oob` is low whenever `rd_done` is low.
- R8: When a read and pointer writes happen in the same cycle, the read uses the pointer value from before the writes.
- R9: On the lower byte, a write takes priority over an add, and an add takes priority over a step. On the middle byte, a write takes priority over a step. The carry flag changes only in a cycle with an add command, and a write to the lower byte in that cycle leaves it unchanged.
- R10: The middle-byte bits at and above position ADDR_W-8 have no effect on the address that is read.
- R11: Both result registers keep their value in every cycle without a read command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_hi | input | 1 | Load `wr_data` into the upper pointer byte |
| wr_mid | input | 1 | Load `wr_data` into the middle pointer byte |
| wr_lo | input | 1 | Load `wr_data` into the lower pointer byte |
| wr_data | input | 8 | Value for pointer writes |
| inc_lo | input | 1 | Step the lower pointer byte by one |
| inc_mid | input | 1 | Step the middle pointer byte by one |
| add_lo | input | 1 | Add `add_val` to the lower pointer byte |
| add_val | input | 8 | Addend for the lower byte |
| rd_req | input | 1 | Read the addressed program word |
| ptr_hi | output | 8 | Upper pointer byte |
| ptr_mid | output | 8 | Middle pointer byte |
| ptr_lo | output | 8 | Lower pointer byte |
| carry | output | 1 | Carry out of the last applied add |
| skip | output | 1 | A step just produced zero |
| acc_out | output | 8 | Lower byte of the last read word |
| res_hi | output | 8 | Upper byte of the last read word |
| rd_done | output | 1 | Results were updated this cycle |
| rd_oob | output | 1 | The last read was out of range |

## Verification
A wrong pointer byte shows up on its own output at the next edge. It also corrupts the results of the next read, one cycle after that read is issued. A wrongly inserted carry from the lower byte into the middle byte appears as soon as the lower byte wraps, and a wrong carry or skip flag shows in the cycle after the command that produced it. A lost hold on the result registers shows the cycle after any idle edge, and a faulty address slice shows up as a wrong result when the middle byte is read with nonzero upper bits.

// File: rtl/tblptr_pkg.sv
package tblptr_pkg;
   localparam int BYTE_W = 8;
   localparam int WORD_W = 2 * BYTE_W;

   // Computed program memory contents for a zero-extended word address
   function automatic logic [WORD_W-1:0] rom_word(input logic [WORD_W-1:0] a);
      logic [BYTE_W-1:0] up;
      logic [BYTE_W-1:0] dn;
      up = a[WORD_W-1:BYTE_W] ^ {a[3:0], 4'h0} ^ 8'h96;
      dn = a[BYTE_W-1:0] ^ 8'hC3;
      return {up, dn};
   endfunction
endpackage

// File: rtl/tblptr_regs.sv
module tblptr_regs
   import tblptr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hi,
   input  logic              wr_mid,
   input  logic              wr_lo,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              inc_lo,
   input  logic              inc_mid,
   input  logic              add_lo,
   input  logic [BYTE_W-1:0] add_val,
   output logic [BYTE_W-1:0] hi_q,
   output logic [BYTE_W-1:0] mid_q,
   output logic [BYTE_W-1:0] lo_q,
   output logic              carry_q,
   output logic              skip_q
);
   logic [BYTE_W:0]   sum;
   logic [BYTE_W-1:0] lo_step;
   logic [BYTE_W-1:0] mid_step;
   logic              lo_step_used;
   logic              mid_step_used;

   always_comb begin
      sum           = {1'b0, lo_q} + {1'b0, add_val};
      lo_step       = lo_q + 1'b1;
      mid_step      = mid_q + 1'b1;
      lo_step_used  = inc_lo && !wr_lo && !add_lo;
      mid_step_used = inc_mid && !wr_mid;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q    <= '0;
         mid_q   <= '0;
         lo_q    <= '0;
         carry_q <= 1'b0;
         skip_q  <= 1'b0;
      end else begin
         if (wr_hi) hi_q <= wr_data;

         if (wr_mid)       mid_q <= wr_data;
         else if (inc_mid) mid_q <= mid_step;

         if (wr_lo) begin
            lo_q <= wr_data;
         end else if (add_lo) begin
            lo_q    <= sum[BYTE_W-1:0];
            carry_q <= sum[BYTE_W];
         end else if (inc_lo) begin
            lo_q <= lo_step;
         end

         skip_q <= (lo_step_used && (lo_step == '0)) ||
                   (mid_step_used && (mid_step == '0));
      end
   end
endmodule

// File: rtl/tblptr_addr.sv
module tblptr_addr
   import tblptr_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter bit HI_CHECK = 1'b1
) (
   input  logic [BYTE_W-1:0] hi,
   input  logic [BYTE_W-1:0] mid,
   input  logic [BYTE_W-1:0] lo,
   output logic [ADDR_W-1:0] addr,
   output logic              oob
);
   localparam int MID_BITS = ADDR_W - BYTE_W;

   generate
      if (MID_BITS == BYTE_W) begin : g_full_mid
         assign addr = {mid, lo};
      end else begin : g_part_mid
         assign addr = {mid[MID_BITS-1:0], lo};
      end

      if (HI_CHECK) begin : g_hi_chk
         assign oob = |hi;
      end else begin : g_hi_ign
         logic unused_hi;
         assign unused_hi = |hi;
         assign oob = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/tblptr_rom.sv
module tblptr_rom
   import tblptr_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [WORD_W-1:0] word
);
   logic [WORD_W-1:0] addr_ext;

   generate
      if (ADDR_W == WORD_W) begin : g_wide
         assign addr_ext = addr;
      end else begin : g_pad
         assign addr_ext = {{(WORD_W-ADDR_W){1'b0}}, addr};
      end
   endgenerate

   assign word = rom_word(addr_ext);
endmodule

// File: rtl/tblptr_result.sv
module tblptr_result
   import tblptr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic              oob_in,
   input  logic [WORD_W-1:0] word,
   output logic [BYTE_W-1:0] acc_q,
   output logic [BYTE_W-1:0] hi_q,
   output logic              done_q,
   output logic              oob_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         hi_q   <= '0;
         done_q <= 1'b0;
         oob_q  <= 1'b0;
      end else begin
         done_q <= rd_req;
         oob_q  <= rd_req && oob_in;
         if (rd_req) begin
            if (oob_in) begin
               acc_q <= '0;
               hi_q  <= '0;
            end else begin
               acc_q <= word[BYTE_W-1:0];
               hi_q  <= word[WORD_W-1:BYTE_W];
            end
         end
      end
   end
endmodule

// File: rtl/tblptr_unit.sv
module tblptr_unit
   import tblptr_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter bit HI_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hi,
   input  logic              wr_mid,
   input  logic              wr_lo,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              inc_lo,
   input  logic              inc_mid,
   input  logic              add_lo,
   input  logic [BYTE_W-1:0] add_val,
   input  logic              rd_req,
   output logic [BYTE_W-1:0] ptr_hi,
   output logic [BYTE_W-1:0] ptr_mid,
   output logic [BYTE_W-1:0] ptr_lo,
   output logic              carry,
   output logic              skip,
   output logic [BYTE_W-1:0] acc_out,
   output logic [BYTE_W-1:0] res_hi,
   output logic              rd_done,
   output logic              rd_oob
);
   generate
      if (ADDR_W <= BYTE_W || ADDR_W > WORD_W) begin : g_bad_width
         $error("tblptr_unit: ADDR_W must lie in (BYTE_W, 2*BYTE_W]");
      end
   endgenerate

   logic [ADDR_W-1:0] word_addr;
   logic              addr_oob;
   logic [WORD_W-1:0] rom_data;

   tblptr_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hi   (wr_hi),
      .wr_mid  (wr_mid),
      .wr_lo   (wr_lo),
      .wr_data (wr_data),
      .inc_lo  (inc_lo),
      .inc_mid (inc_mid),
      .add_lo  (add_lo),
      .add_val (add_val),
      .hi_q    (ptr_hi),
      .mid_q   (ptr_mid),
      .lo_q    (ptr_lo),
      .carry_q (carry),
      .skip_q  (skip)
   );

   tblptr_addr #(.ADDR_W(ADDR_W), .HI_CHECK(HI_CHECK)) u_addr (
      .hi   (ptr_hi),
      .mid  (ptr_mid),
      .lo   (ptr_lo),
      .addr (word_addr),
      .oob  (addr_oob)
   );

   tblptr_rom #(.ADDR_W(ADDR_W)) u_rom (
      .addr (word_addr),
      .word (rom_data)
   );

   tblptr_result u_result (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_req (rd_req),
      .oob_in (addr_oob),
      .word   (rom_data),
      .acc_q  (acc_out),
      .hi_q   (res_hi),
      .done_q (rd_done),
      .oob_q  (rd_oob)
   );
endmodule

// File: rtl/tblptr_chk.sv
module tblptr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_lo,
   input logic       wr_mid,
   input logic       inc_lo,
   input logic       inc_mid,
   input logic       add_lo,
   input logic       rd_req,
   input logic [7:0] ptr_hi,
   input logic [7:0] ptr_mid,
   input logic [7:0] ptr_lo,
   input logic       carry,
   input logic       skip,
   input logic [7:0] acc_out,
   input logic [7:0] res_hi,
   input logic       rd_done,
   input logic       rd_oob
);
   AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_done); // R3
   AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |-> $past(rd_req)); // R3
   AST_LO_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_lo && !wr_lo && !add_lo && ptr_lo == 8'hFF) |=> (ptr_lo == 8'h00)); // R4
   AST_MID_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      ((inc_lo || add_lo) && !wr_mid && !inc_mid) |=> $stable(ptr_mid)); // R5
   AST_SKIP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      skip |-> $past(inc_lo || inc_mid)); // R6
   AST_OOB_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && ptr_hi != 8'h00) |=> (rd_oob && acc_out == 8'h00 && res_hi == 8'h00)); // R7
   AST_OOB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_oob |-> rd_done); // R7
   AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !add_lo |=> $stable(carry)); // R9
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> ($stable(acc_out) && $stable(res_hi))); // R11
endmodule

bind tblptr_unit tblptr_chk u_chk (.*);

// File: tb/tblptr_unit_bench.sv
`timescale 1ns/1ps
module tblptr_unit_bench;
   localparam int ADDR_W = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_hi = 0, wr_mid = 0, wr_lo = 0, inc_lo = 0, inc_mid = 0, add_lo = 0, rd_req = 0;
   logic [7:0] wr_data = 0, add_val = 0;
   logic [7:0] ptr_hi, ptr_mid, ptr_lo, acc_out, res_hi;
   logic       carry, skip, rd_done, rd_oob;

   int checks = 0;
   int errors = 0;

   // reference state
   int m_hi, m_mid, m_lo, m_carry, m_skip, m_acc, m_rh, m_done, m_oob;

   always #2.5 clk = ~clk;

   tblptr_unit #(.ADDR_W(ADDR_W)) u_tblptr_unit (.*);

   function automatic int word_up(int a);
      return ((a >> 8) ^ ((a & 15) << 4) ^ 'h96) & 255;
   endfunction
   function automatic int word_dn(int a);
      return (a & 255) ^ 'hC3;
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_hi = 0; m_mid = 0; m_lo = 0; m_carry = 0; m_skip = 0;
      m_acc = 0; m_rh = 0; m_done = 0; m_oob = 0;
   endtask

   task automatic model_edge();
      int a, n_mid, n_lo, n_hi, n_carry, n_skip;
      m_done = rd_req;
      m_oob  = 0;
      if (rd_req) begin
         a = ((m_mid % (1 << (ADDR_W - 8))) << 8) | m_lo;
         if (m_hi != 0) begin m_acc = 0; m_rh = 0; m_oob = 1; end
         else begin m_acc = word_dn(a); m_rh = word_up(a); end
      end
      n_hi = wr_hi ? int'(wr_data) : m_hi;
      n_mid = m_mid; n_lo = m_lo; n_carry = m_carry; n_skip = 0;
      if (wr_mid) n_mid = wr_data;
      else if (inc_mid) begin n_mid = (m_mid + 1) % 256; if (n_mid == 0) n_skip = 1; end
      if (wr_lo) n_lo = wr_data;
      else if (add_lo) begin n_lo = (m_lo + add_val) % 256; n_carry = (m_lo + add_val) > 255; end
      else if (inc_lo) begin n_lo = (m_lo + 1) % 256; if (n_lo == 0) n_skip = 1; end
      m_hi = n_hi; m_mid = n_mid; m_lo = n_lo; m_carry = n_carry; m_skip = n_skip;
   endtask

   task automatic compare_all();
      chk("R2 ptr_hi", ptr_hi, m_hi);
      chk("R2 ptr_mid", ptr_mid, m_mid);
      chk("R2 ptr_lo", ptr_lo, m_lo);
      chk("R5 carry", carry, m_carry);
      chk("R6 skip", skip, m_skip);
      chk("R3 acc_out", acc_out, m_acc);
      chk("R3 res_hi", res_hi, m_rh);
      chk("R3 rd_done", rd_done, m_done);
      chk("R7 rd_oob", rd_oob, m_oob);
   endtask

   // inputs are already set; advance one edge, then compare at the falling edge
   task automatic cyc();
      @(posedge clk);
      if (rst_n) model_edge(); else model_reset();
      @(negedge clk);
      compare_all();
      {wr_hi, wr_mid, wr_lo, inc_lo, inc_mid, add_lo, rd_req} = '0;
   endtask

   task automatic wr(int which, int v);
      wr_data = v[7:0];
      if (which == 2) wr_hi = 1; else if (which == 1) wr_mid = 1; else wr_lo = 1;
      cyc();
   endtask

   task automatic rd();
      rd_req = 1;
      cyc();
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int a0;
      model_reset();
      @(negedge clk);
      cyc(); cyc();
      chk("R1 ptr_lo", ptr_lo, 0);
      chk("R1 acc_out", acc_out, 0);
      chk("R1 rd_done", rd_done, 0);
      rst_n = 1;
      cyc();

      // basic reads at several addresses
      wr(1, 'h03); wr(0, 'h45); rd();
      chk("R3 acc 0x345", acc_out, 'h45 ^ 'hC3);
      chk("R3 hi 0x345", res_hi, ((3) ^ (5 << 4) ^ 'h96) & 255);
      wr(1, 'h0F); wr(0, 'hFF); rd();
      wr(1, 'h00); wr(0, 'h00); rd();

      // R11: results hold across idle cycles
      a0 = acc_out;
      cyc(); cyc(); cyc();
      chk("R11 acc hold", acc_out, a0);

      // R4: lower byte wraps without touching middle
      wr(1, 'h07); wr(0, 'hFE);
      inc_lo = 1; cyc();
      inc_lo = 1; cyc();
      chk("R4 lo wrap", ptr_lo, 0);
      chk("R4 mid kept", ptr_mid, 'h07);
      chk("R6 skip on wrap", skip, 1);
      inc_mid = 1; cyc();
      rd();

      // R5: add with and without carry
      wr(0, 'hF0); add_val = 'h20; add_lo = 1; cyc();
      chk("R5 sum", ptr_lo, 'h10);
      chk("R5 carry set", carry, 1);
      chk("R5 mid kept", ptr_mid, 'h08);
      add_val = 'h01; add_lo = 1; cyc();
      chk("R5 carry clear", carry, 0);

      // middle byte wrap and skip
      wr(1, 'hFF); inc_mid = 1; cyc();
      chk("R6 mid wrap skip", skip, 1);

      // R10: upper middle bits ignored
      wr(1, 'hF3); wr(0, 'h21); rd();
      a0 = acc_out;
      wr(1, 'h03); rd();
      chk("R10 mid upper ignored", acc_out, a0);

      // R7: out of range
      wr(2, 'h01); rd();
      chk("R7 oob flag", rd_oob, 1);
      chk("R7 acc zero", acc_out, 0);
      wr(2, 'h00); rd();
      chk("R7 oob clear", rd_oob, 0);

      // R8: read with simultaneous writes uses old pointer (0x321)
      wr_lo = 1; wr_mid = 1; wr_data = 'h99; rd_req = 1; cyc();
      chk("R8 old ptr acc", acc_out, 'h21 ^ 'hC3);
      chk("R8 new ptr", ptr_lo, 'h99);

      // R9: priorities on the lower and middle bytes
      wr_data = 'h55; wr_lo = 1; add_lo = 1; add_val = 'hFF; inc_lo = 1; cyc();
      chk("R9 write wins lo", ptr_lo, 'h55);
      chk("R9 carry untouched", carry, 0);
      add_val = 'h02; add_lo = 1; inc_lo = 1; cyc();
      chk("R9 add beats step", ptr_lo, 'h57);
      wr_data = 'h11; wr_mid = 1; inc_mid = 1; cyc();
      chk("R9 write wins mid", ptr_mid, 'h11);

      // R6: a step that is overridden gives no skip
      wr(0, 'hFF);
      wr_data = 'h00; wr_lo = 1; inc_lo = 1; cyc();
      chk("R6 no skip when overridden", skip, 0);

      // sweep of reads through a table with software carry handling
      wr(1, 'h00); wr(0, 'hFC);
      for (int i = 0; i < 8; i++) begin
         rd_req = 1; inc_lo = 1; cyc();
         if (skip) begin inc_mid = 1; cyc(); end
      end
      rd();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule